// File: doc/BRIEF.md
# Multi-Lane Serial SRAM Slave

This block is the target side of a serial memory port that moves data over one, two or four data lanes. A host selects it with an active-low chip select and clocks it with a serial clock. The host sends an opcode, a 16-bit address and then data. The block turns the serial stream into bytes for a small internal byte array, and turns array bytes back into a serial stream. All lane signals are sampled in the block's own system clock domain, so serial clock edges are found by comparing each sample with the one before it.

The lane width is part of the block's state. Two opcodes ask for a wider interface (0x3B for two lanes, 0x38 for four lanes). A third opcode, 0xFF, asks for a return to one lane. The requested width is held as pending and only becomes current when chip select is released. It then stays in force across later transactions. On wide reads, one dummy byte of clocks separates the address from the data. All lanes are released during it, and the output enables turn on only for the data itself. Every lane has its own output enable, so a pad ring can build four bidirectional pins.

Top module: `sio_multilane_sram`

## Requirements
- R1: After reset the block is in one-lane mode and drives no lane: `sio_oe` is 0 and `sio_out` is 0.
- R2: In one-lane mode the block samples bits on `sio_in[0]` at each rising serial clock edge, MSB first. Opcode 0x02 writes bytes starting at the 16-bit address. Opcode 0x03 reads them back on `sio_out[1]` alone, with `sio_oe` = 4'b0010 during data. The first data bit is driven after the falling edge of the clock that carried the last address bit.
- R3: Opcode 0x3B selects two lanes and opcode 0x38 selects four lanes. The new width applies from the transaction that follows the release of chip select.
- R4: In two-lane mode each clock moves two bits MSB first, with the higher bit on lane 1 and the lower on lane 0, in both directions. Read data is driven with `sio_oe` = 4'b0011.
- R5: In four-lane mode each clock moves one nibble MSB first, with the highest bit on lane 3. Read data is driven with `sio_oe` = 4'b1111.
- R6: A read in two- or four-lane mode puts one dummy byte after the address: 4 clocks at two lanes, 2 clocks at four lanes. All lanes stay undriven during the dummy byte, and the data starts right after it.
- R7: The current width does not change when chip select toggles, and stays in force over any number of transactions until a width opcode is taken.
- R8: Opcode 0xFF sent at the current width returns the block to one-lane mode for the next transaction. At two lanes this is 4 clocks of all-ones on lanes 1:0; at four lanes it is 2 clocks of all-ones on lanes 3:0.
- R9: `sio_out` and `sio_oe` change only in the system clock cycle that follows a falling serial clock edge, or when chip select is released.
- R10: During a burst read or write, the address pointer advances by one after each byte, so successive bytes go to consecutive addresses.
- R11: No lane is driven while chip select is high or outside the read data phase. Lanes 2 and 3 are driven only in four-lane mode.
- R12: Any opcode other than those listed above is ignored for the rest of the transaction. No lane is driven and no array byte changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host, slower than `clk` |
| sio_in | input | 4 | Sampled level of the four data lanes |
| sio_out | output | 4 | Value driven onto each data lane |
| sio_oe | output | 4 | Per-lane output enable |

## Verification
Two events share one serial clock. The rising edge that completes the address (or the dummy byte) moves the block into the data phase. The falling edge of that same clock must already drive the first data bits. The bench records the lanes after each falling edge and after each rising edge. It then requires the data bytes to be assembled from exactly the beat that closes the address or dummy, with every earlier beat undriven. It also requires the value seen at the rising edge to equal the one from the previous falling edge. A write burst has a similar overlap: the byte commit and the pointer step fall on one rising edge. This is judged by reading back multi-byte bursts at a different lane width than the one used to write them.

// File: rtl/sio_pkg.sv
package sio_pkg;

   typedef enum logic [1:0] {
      LW_1 = 2'd0,
      LW_2 = 2'd1,
      LW_4 = 2'd2
   } lane_w_e;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR,
      PH_DUMMY,
      PH_RDATA,
      PH_WDATA,
      PH_SKIP
   } phase_e;

   localparam logic [7:0] OP_WRITE = 8'h02;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_DUAL  = 8'h3B;
   localparam logic [7:0] OP_QUAD  = 8'h38;
   localparam logic [7:0] OP_ONE   = 8'hFF;

   function automatic logic [3:0] beat_width(input lane_w_e w);
      case (w)
         LW_2:    return 4'd2;
         LW_4:    return 4'd4;
         default: return 4'd1;
      endcase
   endfunction

endpackage

// File: rtl/sio_width_ctrl.sv
module sio_width_ctrl
   import sio_pkg::*;
#(
   parameter bit QUAD_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_done,
   input  logic [7:0] cmd_byte,
   input  logic       cs_rise,
   output lane_w_e    width
);

   lane_w_e pend_q;
   lane_w_e width_q;
   logic    quad_req;

   generate
      if (QUAD_EN) begin : g_quad
         assign quad_req = (cmd_byte == OP_QUAD);
      end else begin : g_noquad
         assign quad_req = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= LW_1;
         width_q <= LW_1;
      end else begin
         if (cmd_done) begin
            if (cmd_byte == OP_DUAL) begin
               pend_q <= LW_2;
            end else if (quad_req) begin
               pend_q <= LW_4;
            end else if (cmd_byte == OP_ONE) begin
               pend_q <= LW_1;
            end
         end
         if (cs_rise) begin
            width_q <= pend_q;
         end
      end
   end

   assign width = width_q;

endmodule

// File: rtl/sio_lane_map.sv
module sio_lane_map
   import sio_pkg::*;
#(
   parameter int LANES = 4
) (
   input  lane_w_e          width,
   input  logic [LANES-1:0] lane_in,
   input  logic [3:0]       tx_nib,
   output logic [3:0]       rx_bits,
   output logic [LANES-1:0] drv_val,
   output logic [LANES-1:0] drv_en
);

   if (LANES != 4) begin : g_bad_lanes
      $error("sio_lane_map needs exactly four lanes");
   end

   always_comb begin
      case (width)
         LW_2:    rx_bits = {2'b00, lane_in[1:0]};
         LW_4:    rx_bits = lane_in[3:0];
         default: rx_bits = {3'b000, lane_in[0]};
      endcase
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int DUAL_SRC = (i < 2) ? i + 2 : 3;
      always_comb begin
         case (width)
            LW_4: begin
               drv_en[i]  = 1'b1;
               drv_val[i] = tx_nib[i];
            end
            LW_2: begin
               drv_en[i]  = (i < 2);
               drv_val[i] = (i < 2) ? tx_nib[DUAL_SRC] : 1'b0;
            end
            default: begin
               drv_en[i]  = (i == 1);
               drv_val[i] = (i == 1) ? tx_nib[3] : 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/sio_byte_array.sv
module sio_byte_array #(
   parameter int DEPTH = 256,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/sio_multilane_sram.sv
module sio_multilane_sram
   import sio_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int MEM_DEPTH = 256,
   parameter bit QUAD_EN   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic [3:0] sio_in,
   output logic [3:0] sio_out,
   output logic [3:0] sio_oe
);

   localparam int MEM_AW     = $clog2(MEM_DEPTH);
   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam int AB_W       = $clog2(ADDR_BYTES + 1);

   if ((ADDR_W % 8) != 0 || ADDR_W < 8) begin : g_bad_aw
      $error("ADDR_W must be a non-zero multiple of 8");
   end
   if (MEM_DEPTH < 2 || (1 << MEM_AW) != MEM_DEPTH || MEM_AW > ADDR_W) begin : g_bad_depth
      $error("MEM_DEPTH must be a power of two that fits the address");
   end

   logic            sck_q;
   logic            cs_q;
   logic            sck_rise;
   logic            sck_fall;
   logic            cs_rise;
   lane_w_e         width_q;
   phase_e          phase_q;
   logic            rd_q;
   logic [AB_W-1:0] ab_cnt;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]      rx_sr;
   logic [7:0]      rx_next;
   logic [3:0]      rx_bits;
   logic [3:0]      bit_cnt;
   logic [3:0]      bit_sum;
   logic [3:0]      beat_bits;
   logic            byte_done;
   logic            cmd_done;
   logic [7:0]      tx_sr;
   logic [7:0]      tx_cur;
   logic [7:0]      tx_next;
   logic [3:0]      tx_cnt;
   logic [3:0]      tx_sum;
   logic [7:0]      mem_rdata;
   logic            mem_we;
   logic [3:0]      drv_val;
   logic [3:0]      drv_en;
   logic [3:0]      out_q;
   logic [3:0]      oe_q;

   assign sck_rise = !cs_n && sck && !sck_q;
   assign sck_fall = !cs_n && !sck && sck_q;
   assign cs_rise  = cs_n && !cs_q;

   assign beat_bits = beat_width(width_q);
   assign bit_sum   = bit_cnt + beat_bits;
   assign byte_done = sck_rise && (bit_sum == 4'd8);
   assign cmd_done  = byte_done && (phase_q == PH_CMD);

   always_comb begin
      case (width_q)
         LW_2:    rx_next = {rx_sr[5:0], rx_bits[1:0]};
         LW_4:    rx_next = {rx_sr[3:0], rx_bits[3:0]};
         default: rx_next = {rx_sr[6:0], rx_bits[0]};
      endcase
   end

   assign tx_cur  = (tx_cnt == 4'd0) ? mem_rdata : tx_sr;
   assign tx_next = tx_cur << beat_bits;
   assign tx_sum  = tx_cnt + beat_bits;
   assign mem_we  = byte_done && (phase_q == PH_WDATA);

   sio_width_ctrl #(
      .QUAD_EN (QUAD_EN)
   ) u_width (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_done (cmd_done),
      .cmd_byte (rx_next),
      .cs_rise  (cs_rise),
      .width    (width_q)
   );

   sio_lane_map #(
      .LANES (4)
   ) u_lanes (
      .width   (width_q),
      .lane_in (sio_in),
      .tx_nib  (tx_cur[7:4]),
      .rx_bits (rx_bits),
      .drv_val (drv_val),
      .drv_en  (drv_en)
   );

   sio_byte_array #(
      .DEPTH (MEM_DEPTH)
   ) u_array (
      .clk   (clk),
      .we    (mem_we),
      .waddr (addr_q[MEM_AW-1:0]),
      .wdata (rx_next),
      .raddr (addr_q[MEM_AW-1:0]),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         cs_q    <= 1'b1;
         phase_q <= PH_CMD;
         rd_q    <= 1'b0;
         ab_cnt  <= '0;
         addr_q  <= '0;
         rx_sr   <= '0;
         bit_cnt <= '0;
         tx_sr   <= '0;
         tx_cnt  <= '0;
         out_q   <= '0;
         oe_q    <= '0;
      end else begin
         sck_q <= sck;
         cs_q  <= cs_n;
         if (cs_n) begin
            phase_q <= PH_CMD;
            ab_cnt  <= '0;
            bit_cnt <= '0;
            tx_cnt  <= '0;
            out_q   <= '0;
            oe_q    <= '0;
         end else begin
            if (sck_rise) begin
               rx_sr   <= rx_next;
               bit_cnt <= byte_done ? 4'd0 : bit_sum;
               if (byte_done) begin
                  case (phase_q)
                     PH_CMD: begin
                        if (rx_next == OP_READ) begin
                           rd_q    <= 1'b1;
                           phase_q <= PH_ADDR;
                        end else if (rx_next == OP_WRITE) begin
                           rd_q    <= 1'b0;
                           phase_q <= PH_ADDR;
                        end else begin
                           phase_q <= PH_SKIP;
                        end
                     end
                     PH_ADDR: begin
                        addr_q <= ADDR_W'({addr_q, rx_next});
                        ab_cnt <= ab_cnt + 1'b1;
                        if (ab_cnt == AB_W'(ADDR_BYTES - 1)) begin
                           if (!rd_q) begin
                              phase_q <= PH_WDATA;
                           end else if (width_q == LW_1) begin
                              phase_q <= PH_RDATA;
                           end else begin
                              phase_q <= PH_DUMMY;
                           end
                        end
                     end
                     PH_DUMMY: phase_q <= PH_RDATA;
                     PH_WDATA: addr_q  <= addr_q + 1'b1;
                     default: ;
                  endcase
               end
            end
            if (sck_fall && phase_q == PH_RDATA) begin
               out_q <= drv_val;
               oe_q  <= drv_en;
               tx_sr <= tx_next;
               if (tx_sum == 4'd8) begin
                  tx_cnt <= 4'd0;
                  addr_q <= addr_q + 1'b1;
               end else begin
                  tx_cnt <= tx_sum;
               end
            end
         end
      end
   end

   assign sio_out = out_q;
   assign sio_oe  = oe_q;

endmodule

// File: rtl/sio_multilane_sram_chk.sv
module sio_multilane_sram_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       sck,
   input logic [3:0] sio_out,
   input logic [3:0] sio_oe,
   input logic [1:0] width
);

   logic ck_sck_q;
   logic ck_cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_sck_q <= 1'b0;
         ck_cs_q  <= 1'b1;
      end else begin
         ck_sck_q <= sck;
         ck_cs_q  <= cs_n;
      end
   end

   // R11: a deselected port leaves every lane released
   p_idle_undriven_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> (sio_oe == 4'b0000));

   // R9: lanes only move after a falling serial clock edge
   p_out_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !(ck_sck_q && !sck)) |=> ($stable(sio_out) && $stable(sio_oe)));

   // R2: the enable pattern is one of the legal lane groups
   p_oe_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sio_oe == 4'b0000) || (sio_oe == 4'b0010) ||
      (sio_oe == 4'b0011) || (sio_oe == 4'b1111));

   // R11: upper lanes only in four-lane mode
   p_upper_lanes_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (width != 2'd2) |-> (sio_oe[3:2] == 2'b00));

   // R7: width only changes at a chip-select release
   p_width_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs_n && !ck_cs_q) |=> $stable(width));

endmodule

bind sio_multilane_sram sio_multilane_sram_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n    (cs_n),
   .sck     (sck),
   .sio_out (sio_out),
   .sio_oe  (sio_oe),
   .width   (width_q)
);

// File: tb/sio_multilane_sram_tb.sv
module sio_multilane_sram_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sck = 1'b0;
   logic [3:0] sio_in = 4'h0;
   logic [3:0] sio_out;
   logic [3:0] sio_oe;

   int n_checks = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [3:0] b_in  [0:127];
   logic [3:0] b_out [0:127];
   logic [3:0] b_oe  [0:127];
   logic [3:0] b_mid [0:127];
   int nb;
   logic [7:0] exp_b [0:7];
   logic [7:0] wr_b  [0:7];

   always #10 clk = ~clk;

   sio_multilane_sram u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .sck     (sck),
      .sio_in  (sio_in),
      .sio_out (sio_out),
      .sio_oe  (sio_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic add_byte(input logic [7:0] v, input int w);
      for (int j = 0; j < (8 >> w); j++) begin
         case (w)
            0:       b_in[nb] = {3'b000, v[7-j]};
            1:       b_in[nb] = {2'b00, v[7-2*j -: 2]};
            default: b_in[nb] = v[7-4*j -: 4];
         endcase
         nb++;
      end
   endtask

   task automatic add_idle(input int n);
      for (int j = 0; j < n; j++) begin
         b_in[nb] = 4'h0;
         nb++;
      end
   endtask

   task automatic run_xfer();
      @(negedge clk) cs_n = 1'b0;
      for (int i = 0; i < nb; i++) begin
         @(negedge clk) sio_in = b_in[i];
         @(negedge clk) sck = 1'b1;
         @(negedge clk) b_mid[i] = sio_out;
         sck = 1'b0;
         @(negedge clk) b_out[i] = sio_out;
         b_oe[i] = sio_oe;
      end
      @(negedge clk) cs_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [7:0] get_byte(input int s, input int w);
      logic [7:0] v = 8'h00;
      for (int j = 0; j < (8 >> w); j++) begin
         case (w)
            0:       v = {v[6:0], b_out[s+j][1]};
            1:       v = {v[5:0], b_out[s+j][1:0]};
            default: v = {v[3:0], b_out[s+j]};
         endcase
      end
      return v;
   endfunction

   task automatic do_cmd(input logic [7:0] op, input int w);
      nb = 0;
      add_byte(op, w);
      run_xfer();
   endtask

   task automatic do_write(input logic [15:0] a, input int n, input int w);
      nb = 0;
      add_byte(8'h02, w);
      add_byte(a[15:8], w);
      add_byte(a[7:0], w);
      for (int b = 0; b < n; b++) add_byte(wr_b[b], w);
      run_xfer();
   endtask

   task automatic do_read(input logic [15:0] a, input int n, input int w, input string req);
      int bpb;
      int first;
      logic [3:0] pat;
      logic quiet;
      logic steady;
      bpb = 8 >> w;
      nb = 0;
      add_byte(8'h03, w);
      add_byte(a[15:8], w);
      add_byte(a[7:0], w);
      if (w != 0) add_byte(8'h00, w);
      first = nb - 1;
      add_idle(n * bpb - 1);
      run_xfer();
      pat = (w == 0) ? 4'b0010 : (w == 1) ? 4'b0011 : 4'b1111;
      quiet = 1'b1;
      for (int i = 0; i < first; i++) if (b_oe[i] != 4'b0000) quiet = 1'b0;
      chk({req, " R6 R11 lanes released before data"}, quiet, 1'b1);
      for (int b = 0; b < n; b++) begin
         chk({req, " data byte"}, get_byte(first + b * bpb, w), exp_b[b]);
      end
      for (int i = first; i < first + n * bpb; i++) begin
         chk({req, " data-phase enables"}, b_oe[i], pat);
      end
      steady = 1'b1;
      for (int i = first + 1; i < first + n * bpb; i++) if (b_mid[i] !== b_out[i-1]) steady = 1'b0;
      chk({req, " R9 lanes hold through rising edge"}, steady, 1'b1);
   endtask

   task automatic t_reset();
      chk("R1 oe after reset", sio_oe, 4'b0000);
      chk("R1 out after reset", sio_out, 4'b0000);
   endtask

   task automatic t_single();
      wr_b[0] = 8'hA5; wr_b[1] = 8'h3C; wr_b[2] = 8'h7E;
      do_write(16'h0010, 3, 0);
      exp_b[0] = 8'hA5; exp_b[1] = 8'h3C; exp_b[2] = 8'h7E;
      do_read(16'h0010, 3, 0, "R1 R2 R10 single burst");
   endtask

   task automatic t_unknown();
      logic quiet;
      nb = 0;
      add_byte(8'h55, 0);
      add_byte(8'h00, 0);
      add_byte(8'h10, 0);
      add_byte(8'hFF, 0);
      add_idle(8);
      run_xfer();
      quiet = 1'b1;
      for (int i = 0; i < nb; i++) if (b_oe[i] != 4'b0000) quiet = 1'b0;
      chk("R12 unknown opcode drives nothing", quiet, 1'b1);
      exp_b[0] = 8'hA5;
      do_read(16'h0010, 1, 0, "R12 array unchanged");
   endtask

   task automatic t_dual();
      do_cmd(8'h3B, 0);
      exp_b[0] = 8'h3C; exp_b[1] = 8'h7E;
      do_read(16'h0011, 2, 1, "R3 R4 R6 dual read");
      wr_b[0] = 8'hC3; wr_b[1] = 8'h5A;
      do_write(16'h0040, 2, 1);
      nb = 0;
      run_xfer();
      exp_b[0] = 8'hC3; exp_b[1] = 8'h5A;
      do_read(16'h0040, 2, 1, "R4 R7 R10 dual write kept");
   endtask

   task automatic t_dual_exit();
      nb = 0;
      add_byte(8'hFF, 1);
      chk("R8 dual exit is four clocks", nb, 4);
      run_xfer();
      exp_b[0] = 8'h5A;
      do_read(16'h0041, 1, 0, "R8 back to one lane");
   endtask

   task automatic t_quad();
      do_cmd(8'h38, 0);
      exp_b[0] = 8'hA5; exp_b[1] = 8'h3C; exp_b[2] = 8'h7E;
      do_read(16'h0010, 3, 2, "R3 R5 R6 quad read");
      wr_b[0] = 8'h12; wr_b[1] = 8'hED;
      do_write(16'h0050, 2, 2);
      nb = 0;
      add_byte(8'hFF, 2);
      chk("R8 quad exit is two clocks", nb, 2);
      run_xfer();
      exp_b[0] = 8'h12; exp_b[1] = 8'hED;
      do_read(16'h0050, 2, 0, "R5 R8 R10 quad write read in one lane");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_single();
      t_unknown();
      t_dual();
      t_dual_exit();
      t_quad();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

endmodule